// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Edge/Level Interrupts

This block is a register-mapped controller for sixteen general-purpose I/O lines. Software writes output values and a direction mask through a 32-bit word-addressed register port and reads the line levels back. Each line has its own trigger detector. The detector can fire on a high level, a low level, a rising edge, a falling edge or any change. A hit sets a sticky pending bit, and software clears that bit by writing a one to it. Pending bits of the lower thirteen lines also appear on dedicated level-high interrupt wires to the processor.

Each input pad first passes through a two-flop synchroniser. Both the input-data register and the detectors see only the synchronised value. An edge is found by comparing this cycle's synchronised sample with the previous one. Two of the upper lines can also be handed to an external clock source through a clock-select register. While that register is zero they behave as ordinary GPIO. A debounce-select word is kept for software and has no effect here.

Top module: `gpio16_ctrl`

## Requirements
- R1: After reset the direction register reads 0xFFFF and every other register reads 0. `pad_oe` and `irq` are all zero.
- R2: Registers sit at these byte offsets: output data 0x00, direction 0x04, input data 0x08, pending status 0x0C, styles of lines 0–7 at 0x10, styles of lines 8–15 at 0x14, clock select 0x18, debounce select 0x1C. Output data and direction read back 16 bits. Style registers keep bits 23:0 and read 0 above them. Clock select keeps bits 1:0. Debounce select keeps all 32 bits.
- R3: Reading 0x08 returns the pad levels delayed by two clock edges, for every line and whatever its direction. A pad change is not yet visible after one edge.
- R4: Line n takes its 3-bit style from bits [3(n mod 8)+2 : 3(n mod 8)] of 0x10 when n < 8 and of 0x14 otherwise. The codes are 0 level high, 1 level low, 2 rising, 3 falling and 4 any change.
- R5: With an edge style, a qualifying change on the synchronised input sets the pending bit one edge later. The bit then stays set after the input returns.
- R6: With a level style, the pending bit is set on every cycle the synchronised input is at its active level. A clear written while the input is still active leaves the bit set.
- R7: Writing 0x0C clears each pending bit whose data bit is 1 and leaves the bits written as 0 unchanged. A hit in the same cycle as a clear leaves the bit set.
- R8: Style codes 5, 6 and 7 never set a pending bit.
- R9: `irq[n]` equals pending bit n for lines 0–12. Pending bits of lines 13–15 are readable at 0x0C but drive no interrupt wire.
- R10: Direction bit 1 releases the line (`pad_oe` low). Bit 0 drives it (`pad_oe` high). `pad_out` always carries the output-data bit of a GPIO line.
- R11: Clock-select bit 0 hands line 14 and bit 1 hands line 15 to `clk_src[0]` and `clk_src[1]`, with the pad driven. When the bit is 0 the line follows R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register (combinational) |
| pad_in | input | 16 | Levels seen at the pads |
| pad_out | output | 16 | Values to drive onto the pads |
| pad_oe | output | 16 | Pad driver enable, 1 drives |
| clk_src | input | 2 | External clocks that can be routed to lines 14 and 15 |
| irq | output | 13 | Level-high interrupt per line 0–12 |

## Verification
The hardest case to reach from the ports is a clearing write that falls in exactly the cycle a new edge is detected. That cycle sits two synchroniser edges after the pad change. The stimulus changes a pad, waits two falling clock edges and then raises the write strobe, so the clear and the detection meet at one rising edge. The level case is reached the same way: a clear is written while the pad is held active, and the pending bit must stay set. A long pseudo-random phase then mixes pad activity, style changes and status writes against a cycle-by-cycle model.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

   localparam int STY_W       = 3;
   localparam int STY_PER_REG = 8;
   localparam int STY_REG_W   = STY_W * STY_PER_REG;
   localparam int STY_ALL_W   = 2 * STY_REG_W;

   typedef enum logic [2:0] {
      STY_LVL_HI    = 3'd0,
      STY_LVL_LO    = 3'd1,
      STY_EDGE_RISE = 3'd2,
      STY_EDGE_FALL = 3'd3,
      STY_EDGE_ANY  = 3'd4
   } trig_style_e;

   // word index = byte offset / 4
   typedef enum logic [2:0] {
      RW_DOUT   = 3'd0,
      RW_DIR    = 3'd1,
      RW_DIN    = 3'd2,
      RW_STAT   = 3'd3,
      RW_STY_LO = 3'd4,
      RW_STY_HI = 3'd5,
      RW_CLKSEL = 3'd6,
      RW_DBSEL  = 3'd7
   } reg_word_e;

   function automatic logic style_fire(input logic [2:0] sty,
                                       input logic cur, input logic prv);
      case (sty)
         STY_LVL_HI:    return cur;
         STY_LVL_LO:    return ~cur;
         STY_EDGE_RISE: return cur & ~prv;
         STY_EDGE_FALL: return ~cur & prv;
         STY_EDGE_ANY:  return cur ^ prv;
         default:       return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio16_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio16_detect.sv
module gpio16_detect
   import gpio16_pkg::*;
#(
   parameter int NLINES = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NLINES-1:0]       smp,
   input  logic [STY_W*NLINES-1:0] sty,
   input  logic [NLINES-1:0]       clr,
   output logic [NLINES-1:0]       hit,
   output logic [NLINES-1:0]       status
);

   logic [NLINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar n = 0; n < NLINES; n++) begin : g_line
      assign hit[n] = style_fire(sty[STY_W*n +: STY_W], smp[n], prev_q[n]);

      // new hit takes priority over a clearing write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status[n] <= 1'b0;
         else        status[n] <= (status[n] & ~clr[n]) | hit[n];
      end
   end

endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
   import gpio16_pkg::*;
#(
   parameter int NLINES = 16,
   parameter int AW     = 5,
   parameter int DW     = 32,
   parameter int NCLK   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        addr,
   input  logic [DW-1:0]        wdata,
   input  logic [NLINES-1:0]    din_sync,
   input  logic [NLINES-1:0]    status,
   output logic [DW-1:0]        rdata,
   output logic [NLINES-1:0]    dout_q,
   output logic [NLINES-1:0]    dir_q,
   output logic [NLINES-1:0]    clr,
   output logic [STY_ALL_W-1:0] sty_q,
   output logic [NCLK-1:0]      clksel_q
);

   localparam int WORD_W = AW - 2;
   localparam int NWORDS = 8;

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic [NWORDS-1:0] wsel;
   logic [DW-1:0]     dbsel_q;

   assign word    = addr[AW-1:2];
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      for (int k = 0; k < NWORDS; k++) begin
         wsel[k] = wr_en && aligned && (word == WORD_W'(k));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q   <= '0;
         dir_q    <= '1;
         sty_q    <= '0;
         clksel_q <= '0;
         dbsel_q  <= '0;
      end else begin
         if (wsel[RW_DOUT])   dout_q   <= wdata[NLINES-1:0];
         if (wsel[RW_DIR])    dir_q    <= wdata[NLINES-1:0];
         if (wsel[RW_STY_LO]) sty_q[STY_REG_W-1:0] <= wdata[STY_REG_W-1:0];
         if (wsel[RW_STY_HI]) sty_q[STY_ALL_W-1:STY_REG_W] <= wdata[STY_REG_W-1:0];
         if (wsel[RW_CLKSEL]) clksel_q <= wdata[NCLK-1:0];
         if (wsel[RW_DBSEL])  dbsel_q  <= wdata;
      end
   end

   assign clr = wsel[RW_STAT] ? wdata[NLINES-1:0] : '0;

   always_comb begin
      rdata = '0;
      if (aligned) begin
         case (word)
            WORD_W'(RW_DOUT):   rdata = DW'(dout_q);
            WORD_W'(RW_DIR):    rdata = DW'(dir_q);
            WORD_W'(RW_DIN):    rdata = DW'(din_sync);
            WORD_W'(RW_STAT):   rdata = DW'(status);
            WORD_W'(RW_STY_LO): rdata = DW'(sty_q[STY_REG_W-1:0]);
            WORD_W'(RW_STY_HI): rdata = DW'(sty_q[STY_ALL_W-1:STY_REG_W]);
            WORD_W'(RW_CLKSEL): rdata = DW'(clksel_q);
            WORD_W'(RW_DBSEL):  rdata = dbsel_q;
            default:            rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio16_padmux.sv
module gpio16_padmux #(
   parameter int NLINES    = 16,
   parameter int NCLK      = 2,
   parameter int CLK_LINE0 = 14
) (
   input  logic [NLINES-1:0] dout_q,
   input  logic [NLINES-1:0] dir_q,
   input  logic [NCLK-1:0]   clksel_q,
   input  logic [NCLK-1:0]   clk_src,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_oe
);

   for (genvar n = 0; n < NLINES; n++) begin : g_pad
      if (n >= CLK_LINE0 && n < CLK_LINE0 + NCLK) begin : g_clkable
         localparam int K = n - CLK_LINE0;
         assign pad_out[n] = clksel_q[K] ? clk_src[K] : dout_q[n];
         assign pad_oe[n]  = clksel_q[K] | ~dir_q[n];
      end else begin : g_plain
         assign pad_out[n] = dout_q[n];
         assign pad_oe[n]  = ~dir_q[n];
      end
   end

endmodule

// File: rtl/gpio16_ctrl.sv
module gpio16_ctrl
   import gpio16_pkg::*;
#(
   parameter int NLINES    = 16,
   parameter int NIRQ      = 13,
   parameter int AW        = 5,
   parameter int DW        = 32,
   parameter int NCLK      = 2,
   parameter int CLK_LINE0 = 14,
   parameter int SYNC_STG  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [NLINES-1:0] pad_in,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_oe,
   input  logic [NCLK-1:0]   clk_src,
   output logic [NIRQ-1:0]   irq
);

   if (NLINES < 1 || NLINES > 2 * STY_PER_REG) begin : g_bad_lines
      $error("gpio16_ctrl: NLINES out of range");
   end
   if (NIRQ < 1 || NIRQ > NLINES) begin : g_bad_irq
      $error("gpio16_ctrl: NIRQ must be within 1..NLINES");
   end
   if (AW < 5) begin : g_bad_aw
      $error("gpio16_ctrl: AW must cover eight word registers");
   end
   if (DW < STY_REG_W || DW < NLINES) begin : g_bad_dw
      $error("gpio16_ctrl: DW too narrow");
   end
   if (NCLK < 1 || CLK_LINE0 + NCLK > NLINES) begin : g_bad_clk
      $error("gpio16_ctrl: clock lines fall outside the line range");
   end

   logic [NLINES-1:0]    din_sync_w;
   logic [NLINES-1:0]    status_w;
   logic [NLINES-1:0]    hit_w;
   logic [NLINES-1:0]    clr_w;
   logic [NLINES-1:0]    dout_w;
   logic [NLINES-1:0]    dir_w;
   logic [STY_ALL_W-1:0] sty_w;
   logic [NCLK-1:0]      clksel_w;

   gpio16_sync #(.W(NLINES), .STAGES(SYNC_STG)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (din_sync_w)
   );

   gpio16_regs #(.NLINES(NLINES), .AW(AW), .DW(DW), .NCLK(NCLK)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .din_sync (din_sync_w),
      .status   (status_w),
      .rdata    (rdata),
      .dout_q   (dout_w),
      .dir_q    (dir_w),
      .clr      (clr_w),
      .sty_q    (sty_w),
      .clksel_q (clksel_w)
   );

   gpio16_detect #(.NLINES(NLINES)) detect_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp    (din_sync_w),
      .sty    (sty_w[STY_W*NLINES-1:0]),
      .clr    (clr_w),
      .hit    (hit_w),
      .status (status_w)
   );

   gpio16_padmux #(.NLINES(NLINES), .NCLK(NCLK), .CLK_LINE0(CLK_LINE0)) padmux_i (
      .dout_q   (dout_w),
      .dir_q    (dir_w),
      .clksel_q (clksel_w),
      .clk_src  (clk_src),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   assign irq = status_w[NIRQ-1:0];

endmodule

// File: rtl/gpio16_ctrl_chk.sv
module gpio16_ctrl_chk
   import gpio16_pkg::*;
#(
   parameter int NLINES = 16,
   parameter int NIRQ   = 13,
   parameter int AW     = 5,
   parameter int NCLK   = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [AW-1:0]           addr,
   input logic [NLINES-1:0]       wdata_lo,
   input logic [NIRQ-1:0]         rdata_lo,
   input logic [NLINES-1:0]       pad_oe,
   input logic [NIRQ-1:0]         irq,
   input logic [NLINES-1:0]       status,
   input logic [NLINES-1:0]       hit,
   input logic [STY_W*NLINES-1:0] sty,
   input logic [NCLK-1:0]         clksel
);

   localparam logic [AW-1:0] A_STAT = AW'(4 * RW_STAT);
   localparam logic [AW-1:0] A_DIR  = AW'(4 * RW_DIR);

   // R9
   irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_STAT) |-> (rdata_lo == irq));

   // R7
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_STAT) |=> ((status & $past(wdata_lo & ~hit)) == '0));

   // R7
   hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status & $past(hit)) == $past(hit)));

   // R5
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_STAT) |=> ((~status & $past(status)) == '0));

   // R10
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DIR && clksel == '0) |=> (pad_oe == ~$past(wdata_lo)));

   for (genvar n = 0; n < NLINES; n++) begin : g_dis
      // R8
      style_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sty[STY_W*n +: STY_W] > 3'd4) |-> !hit[n]);
   end

endmodule

bind gpio16_ctrl gpio16_ctrl_chk #(
   .NLINES (NLINES),
   .NIRQ   (NIRQ),
   .AW     (AW),
   .NCLK   (NCLK)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata_lo (wdata[NLINES-1:0]),
   .rdata_lo (rdata[NIRQ-1:0]),
   .pad_oe   (pad_oe),
   .irq      (irq),
   .status   (status_w),
   .hit      (hit_w),
   .sty      (sty_w[gpio16_pkg::STY_W*NLINES-1:0]),
   .clksel   (clksel_w)
);

// File: tb/gpio16_ctrl_tb.sv
module gpio16_ctrl_tb_top;

   localparam int N = 16, NIRQ = 13, AW = 5, DW = 32, NCLK = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [DW-1:0]   wdata = '0;
   logic [N-1:0]    pad_in = '0;
   logic [NCLK-1:0] clk_src = '0;
   wire  [DW-1:0]   rdata;
   wire  [N-1:0]    pad_out, pad_oe;
   wire  [NIRQ-1:0] irq;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio16_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .clk_src(clk_src), .irq(irq)
   );

   // ---------------- reference model ----------------
   logic [15:0] m_s1, m_s2, m_prv, m_out, m_dir, m_st;
   logic [47:0] m_sty;
   logic [1:0]  m_cs;
   logic [31:0] m_db;

   function automatic bit fires(int sty, bit cur, bit prv);
      case (sty)
         0: return cur;
         1: return !cur;
         2: return cur && !prv;
         3: return !cur && prv;
         4: return cur != prv;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      logic [15:0] hv;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prv = 0; m_out = 0; m_dir = 16'hFFFF;
         m_st = 0; m_sty = 0; m_cs = 0; m_db = 0;
      end else begin
         for (int i = 0; i < 16; i++) hv[i] = fires(int'(m_sty[3*i +: 3]), m_s2[i], m_prv[i]);
         if (wr_en) begin
            case (addr)
               5'h00: m_out = wdata[15:0];
               5'h04: m_dir = wdata[15:0];
               5'h0C: m_st  = m_st & ~wdata[15:0];
               5'h10: m_sty[23:0]  = wdata[23:0];
               5'h14: m_sty[47:24] = wdata[23:0];
               5'h18: m_cs  = wdata[1:0];
               5'h1C: m_db  = wdata;
               default: ;
            endcase
         end
         m_st  = m_st | hv;
         m_prv = m_s2;
         m_s2  = m_s1;
         m_s1  = pad_in;
      end
   end

   function automatic logic [31:0] m_rd(logic [AW-1:0] a);
      case (a)
         5'h00: return {16'h0, m_out};
         5'h04: return {16'h0, m_dir};
         5'h08: return {16'h0, m_s2};
         5'h0C: return {16'h0, m_st};
         5'h10: return {8'h0, m_sty[23:0]};
         5'h14: return {8'h0, m_sty[47:24]};
         5'h18: return {30'h0, m_cs};
         5'h1C: return m_db;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [15:0] m_oe();
      logic [15:0] v = ~m_dir;
      if (m_cs[0]) v[14] = 1'b1;
      if (m_cs[1]) v[15] = 1'b1;
      return v;
   endfunction

   function automatic logic [15:0] m_po();
      logic [15:0] v = m_out;
      if (m_cs[0]) v[14] = clk_src[0];
      if (m_cs[1]) v[15] = clk_src[1];
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (!done) begin
         chk("R2/R3 rdata vs model", rdata, m_rd(addr));
         chk("R10/R11 pad_oe vs model", 32'(pad_oe), 32'(m_oe()));
         chk("R10/R11 pad_out vs model", 32'(pad_out), 32'(m_po()));
         chk("R9 irq vs model", 32'(irq), 32'(m_st[12:0]));
      end
   end

   // ---------------- directed stimulus helpers ----------------
   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] e);
      @(negedge clk);
      wr_en = 1'b0; addr = a;
      #3;
      chk(tag, rdata, e);
   endtask

   task automatic pads(logic [15:0] v);
      @(negedge clk);
      pad_in = v;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] dis24();
      logic [31:0] v = 0;
      for (int i = 0; i < 8; i++) v |= 32'd5 << (3 * i);
      return v;
   endfunction

   function automatic logic [31:0] sty_set(logic [31:0] b, int f, int val);
      return (b & ~(32'h7 << (3 * f))) | (32'(val) << (3 * f));
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [31:0] dis, r2, rnd;
      dis = dis24();
      repeat (3) @(negedge clk);
      #3;
      chk("R1 pad_oe during reset", 32'(pad_oe), 32'h0);
      chk("R1 irq during reset", 32'(irq), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 direction reset", 5'h04, 32'h0000_FFFF);
      rd_chk("R1 output reset", 5'h00, 32'h0);
      rd_chk("R1 status reset", 5'h0C, 32'h0);
      rd_chk("R1 style lo reset", 5'h10, 32'h0);

      // R2 register map and widths
      wr(5'h10, 32'hFFFF_FFFF);
      rd_chk("R2 style lo masked to 24 bits", 5'h10, 32'h00FF_FFFF);
      wr(5'h10, dis);
      wr(5'h14, dis);
      rd_chk("R2 style hi readback", 5'h14, dis);
      wr(5'h1C, 32'hDEAD_BEEF);
      rd_chk("R2 debounce select readback", 5'h1C, 32'hDEAD_BEEF);
      wr(5'h18, 32'hFFFF_FFFD);
      rd_chk("R2 clock select masked to 2 bits", 5'h18, 32'h1);
      wr(5'h18, 32'h0);

      // R10 direction and output data
      wr(5'h00, 32'h0000_A5A5);
      wr(5'h04, 32'h0000_00FF);
      @(negedge clk); #3;
      chk("R10 pad_oe from direction", 32'(pad_oe), 32'h0000_FF00);
      chk("R10 pad_out driven half", 32'(pad_out & 16'hFF00), 32'h0000_A500);

      // R3 two-stage input sampling
      @(negedge clk); pad_in = 16'h1234;
      @(negedge clk); addr = 5'h08; #3;
      chk("R3 input not visible after one edge", rdata, 32'h0);
      rd_chk("R3 input visible after two edges", 5'h08, 32'h0000_1234);
      pads(16'h0000);

      // R5 rising edge on line 3 (field 3 of 0x10 = 2)
      wr(5'h10, sty_set(dis, 3, 2));
      pads(16'h0008);
      rd_chk("R5 rising edge sets line 3", 5'h0C, 32'h0000_0008);
      #0 chk("R9 irq follows line 3", 32'(irq), 32'h0000_0008);
      pads(16'h0000);
      rd_chk("R5 pending stays after input falls", 5'h0C, 32'h0000_0008);
      wr(5'h0C, 32'h0000_0000);
      rd_chk("R7 zero bits leave pending", 5'h0C, 32'h0000_0008);
      wr(5'h0C, 32'h0000_0008);
      rd_chk("R7 one bit clears pending", 5'h0C, 32'h0);

      // R7 clear and new edge in the same cycle
      @(negedge clk); pad_in[3] = 1'b1;
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; addr = 5'h0C; wdata = 32'h8;
      @(negedge clk); wr_en = 1'b0; #3;
      chk("R7 edge wins over same-cycle clear", rdata, 32'h0000_0008);
      wr(5'h0C, 32'h8);
      pads(16'h0000);

      // R4 any-change on line 0, falling on line 10 (0x14 field 2)
      wr(5'h10, sty_set(dis, 0, 4));
      wr(5'h14, sty_set(dis, 2, 3));
      pads(16'h0001);
      rd_chk("R4 any-change rise on line 0", 5'h0C, 32'h0000_0001);
      wr(5'h0C, 32'h1);
      pads(16'h0000);
      rd_chk("R4 any-change fall on line 0", 5'h0C, 32'h0000_0001);
      wr(5'h0C, 32'h1);
      pads(16'h0400);
      rd_chk("R4 falling style ignores rise on line 10", 5'h0C, 32'h0);
      pads(16'h0000);
      rd_chk("R4 falling style fires on line 10", 5'h0C, 32'h0000_0400);
      #0 chk("R9 irq line 10", 32'(irq), 32'h0000_0400);
      wr(5'h0C, 32'hFFFF);

      // R6 level high on line 9 (0x14 field 1 = 0), R8 code 6 on line 11
      r2 = sty_set(sty_set(sty_set(dis, 2, 3), 1, 0), 3, 6);
      wr(5'h14, r2);
      pads(16'h0200);
      rd_chk("R6 level high sets line 9", 5'h0C, 32'h0000_0200);
      wr(5'h0C, 32'h0200);
      rd_chk("R6 clear while active re-asserts", 5'h0C, 32'h0000_0200);
      pads(16'h0000);
      wr(5'h0C, 32'h0200);
      rd_chk("R6 clear after input inactive", 5'h0C, 32'h0);
      pads(16'h0800);
      pads(16'h0000);
      rd_chk("R8 code 6 never sets line 11", 5'h0C, 32'h0);

      // R9 line 14 level low: pending without interrupt wire
      wr(5'h14, sty_set(r2, 6, 1));
      rd_chk("R9 line 14 pending readable", 5'h0C, 32'h0000_4000);
      #0 chk("R9 line 14 drives no irq", 32'(irq), 32'h0);
      pads(16'h4000);
      wr(5'h0C, 32'h4000);
      rd_chk("R9 line 14 cleared", 5'h0C, 32'h0);

      // R11 clock select on line 15
      wr(5'h04, 32'hFFFF);
      clk_src = 2'b10;
      wr(5'h18, 32'h2);
      @(negedge clk); #3;
      chk("R11 line 15 driven by clock", 32'(pad_oe), 32'h0000_8000);
      chk("R11 line 15 carries clk_src", 32'(pad_out[15]), 32'h1);
      @(negedge clk); clk_src = 2'b00; #3;
      chk("R11 line 15 follows clk_src low", 32'(pad_out[15]), 32'h0);
      wr(5'h18, 32'h0);
      @(negedge clk); #3;
      chk("R11 zero select returns line 15 to GPIO", 32'(pad_oe), 32'h0);

      // pseudo-random phase, checked against the model every cycle
      rnd = 32'h1ACE_B00C;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
         if (rnd[3:0] < 4'd3) pad_in = rnd[31:16];
         clk_src = rnd[5:4];
         wr_en = (rnd[9:8] == 2'b00);
         addr  = {rnd[12:10], 2'b00};
         rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
         wdata = rnd;
      end
      @(negedge clk); wr_en = 1'b0;
      repeat (4) @(negedge clk);
      #4;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule